// File: doc/BRIEF.md
# Pixel Clock Divider With Bypass

This block derives a pixel-rate timing reference from a faster reference clock. It produces two outputs. The first is a one-cycle enable pulse that marks the start of every pixel period. The second is a square-wave pixel clock, built from a register and toggled from the same count. Downstream display logic gates its pixel work on the enable. The square wave is for pins or for logic that needs a level.

The division ratio comes from configuration bits. A divisor field is stored as two separate subfields, which are joined with the high subfield on top. The ratio is that combined value plus two. A separate bypass bit overrides the field and divides by one. The configuration pins are plain control inputs with no handshake. They may change at any time, but the block only captures them at a period boundary. This means software never causes a runt period.

Top module: `pixclk_divider`

## Requirements
- R1: While reset is asserted, `pix_en` and `pix_clk` are low. The ratio N present at the first clock edge after reset governs the first period, and the first `pix_en` appears in the cycle after the N-th edge following reset release.
- R2: With `bypass` low, the ratio is N = {`div_hi`,`div_lo`} + 2, so `pix_en` is high for one cycle in every N cycles. Both subfields at zero give the minimum ratio of 2.
- R3: With `bypass` high, the ratio is 1 whatever the subfields hold: `pix_en` is high every cycle and `pix_clk` stays low.
- R4: `div_hi` supplies bits [9:5] of the combined field and `div_lo` bits [4:0]. For example, `div_hi`=1 with `div_lo`=0 gives N = 34.
- R5: With both subfields all-ones, N = 1025, the largest ratio.
- R6: The inputs are sampled only at the clock edge that ends a period, which is the edge after which `pix_en` rises, and at the first edge after reset. A change at any other time, including a brief change that is withdrawn, has no effect on the current period.
- R7: In each period `pix_clk` is low for ceil(N/2) cycles, starting in the cycle where `pix_en` is high, and is then high for floor(N/2) cycles. For odd N the high phase is one cycle shorter.
- R8: For N of 2 or more, `pix_en` is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | Divide-by-one select; subfields ignored when high |
| div_lo | input | 5 | Low subfield of the divisor field |
| div_hi | input | 5 | High subfield of the divisor field |
| pix_en | output | 1 | One-cycle pulse at the start of each pixel period |
| pix_clk | output | 1 | Registered pixel clock square wave |

## Verification
The bench runs a chain of periods and compares both outputs against a waveform computed from the ratio, cycle by cycle. The chain covers these cases:
- A ratio of 5 right after reset, which fixes the latency of the first pulse.
- Bypass with two different junk subfield values, which shows the subfields are ignored.
- A ratio of 2, the smallest non-bypass ratio.
- Only the high subfield set (ratio 34), which separates the correct join order from a swapped one.
- A ratio of 3, the odd-ratio case, which fixes the asymmetric phase.
- Both subfields all-ones (ratio 1025), which exercises the full counter width.
- Ratios 4 and 8, with a wild value driven briefly early in each period and then withdrawn; any early capture shows up as a wrong period length.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;
  // Default subfield widths of the divisor field
  localparam int unsigned LO_BITS_DEF = 5;
  localparam int unsigned HI_BITS_DEF = 5;
  // Field width and ratio width (field max + 2 needs one extra bit)
  localparam int unsigned FIELD_BITS_DEF = LO_BITS_DEF + HI_BITS_DEF;
  localparam int unsigned RATIO_BITS_DEF = FIELD_BITS_DEF + 1;
endpackage

// File: rtl/pixclk_ratio_dec.sv
module pixclk_ratio_dec #(
  parameter int unsigned LO_BITS = pixclk_pkg::LO_BITS_DEF,
  parameter int unsigned HI_BITS = pixclk_pkg::HI_BITS_DEF,
  localparam int unsigned FW = LO_BITS + HI_BITS,
  localparam int unsigned RW = FW + 1
) (
  input  logic               bypass,
  input  logic [LO_BITS-1:0] sub_lo,
  input  logic [HI_BITS-1:0] sub_hi,
  output logic [RW-1:0]      ratio
);
  logic [FW-1:0] field;

  // High subfield forms the upper bits of the joined field
  assign field = {sub_hi, sub_lo};

  always_comb begin
    if (bypass) ratio = RW'(1);
    else        ratio = RW'(field) + RW'(2);
  end
endmodule

// File: rtl/pixclk_period_ctr.sv
module pixclk_period_ctr #(
  parameter int unsigned RW = pixclk_pkg::RATIO_BITS_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_in,
  output logic [RW-1:0] cnt_nxt,
  output logic [RW-1:0] ratio_nxt,
  output logic          terminal,
  output logic [RW-1:0] ratio_q,
  output logic          loaded,
  output logic          en_q
);
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] ratio_eff;

  always_comb begin
    // Before the first capture the live ratio governs the first period
    ratio_eff = loaded ? ratio_q : ratio_in;
    terminal  = (cnt_q == ratio_eff - RW'(1));
    cnt_nxt   = terminal ? '0 : cnt_q + RW'(1);
    ratio_nxt = (terminal || !loaded) ? ratio_in : ratio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      loaded  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      ratio_q <= ratio_nxt;
      loaded  <= 1'b1;
      en_q    <= terminal;
    end
  end

  // R2: the count never leaves the current period
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> (cnt_q < ratio_q));

  // R6: the captured ratio only moves on a boundary edge
  assert_ratio_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && $past(loaded) && cnt_q != '0) |-> $stable(ratio_q));
endmodule

// File: rtl/pixclk_phase_gen.sv
module pixclk_phase_gen #(
  parameter int unsigned RW = pixclk_pkg::RATIO_BITS_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          terminal,
  input  logic [RW-1:0] cnt_nxt,
  input  logic [RW-1:0] ratio_nxt,
  output logic          pix_clk
);
  logic [RW-1:0] low_len;
  logic          clk_nxt;

  always_comb begin
    // Low phase is ceil(N/2); high phase takes the remainder
    low_len = RW'((ratio_nxt + RW'(1)) >> 1);
    clk_nxt = !terminal && (cnt_nxt >= low_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_clk <= 1'b0;
    else        pix_clk <= clk_nxt;
  end
endmodule

// File: rtl/pixclk_divider.sv
module pixclk_divider #(
  parameter int unsigned LO_BITS = pixclk_pkg::LO_BITS_DEF,
  parameter int unsigned HI_BITS = pixclk_pkg::HI_BITS_DEF,
  localparam int unsigned RW = LO_BITS + HI_BITS + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bypass,
  input  logic [LO_BITS-1:0] div_lo,
  input  logic [HI_BITS-1:0] div_hi,
  output logic               pix_en,
  output logic               pix_clk
);
  logic [RW-1:0] ratio_live;
  logic [RW-1:0] cnt_nxt;
  logic [RW-1:0] ratio_nxt;
  logic [RW-1:0] ratio_q;
  logic          terminal;
  logic          loaded;

  pixclk_ratio_dec #(.LO_BITS(LO_BITS), .HI_BITS(HI_BITS)) u_dec (
    .bypass (bypass),
    .sub_lo (div_lo),
    .sub_hi (div_hi),
    .ratio  (ratio_live)
  );

  pixclk_period_ctr #(.RW(RW)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_in  (ratio_live),
    .cnt_nxt   (cnt_nxt),
    .ratio_nxt (ratio_nxt),
    .terminal  (terminal),
    .ratio_q   (ratio_q),
    .loaded    (loaded),
    .en_q      (pix_en)
  );

  pixclk_phase_gen #(.RW(RW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .terminal  (terminal),
    .cnt_nxt   (cnt_nxt),
    .ratio_nxt (ratio_nxt),
    .pix_clk   (pix_clk)
  );

  // R3: a captured ratio of one pulses every cycle
  assert_bypass_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && ratio_q == RW'(1)) |-> pix_en);

  // R8: pulse is one cycle wide for ratios of two or more
  assert_en_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && ratio_q > RW'(1)) |=> !pix_en);

  // R7: the square wave is low in the cycle that starts a period
  assert_clk_low_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> !pix_clk);
endmodule

// File: tb/pixclk_divider_tb.sv
module pixclk_divider_tb;
  localparam int NP = 15;

  typedef struct {
    bit en;
    bit ck;
    int tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass = 1'b0;
  logic [4:0] div_lo = '0;
  logic [4:0] div_hi = '0;
  logic pix_en;
  logic pix_clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit reported = 0;
  item_t q[$];

  bit     p_byp [NP] = '{0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
  int     p_lo  [NP] = '{3, 31, 31, 5, 0, 0, 0, 1, 1, 31, 2, 2, 6, 0, 0};
  int     p_hi  [NP] = '{0, 31, 31, 17, 0, 0, 1, 0, 0, 31, 0, 0, 0, 0, 0};
  // tag codes: 1..8 name requirement R1..R8
  int     p_tag [NP] = '{1, 3, 3, 3, 2, 8, 4, 7, 7, 5, 6, 6, 6, 3, 2};

  pixclk_divider u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .bypass  (bypass),
    .div_lo  (div_lo),
    .div_hi  (div_hi),
    .pix_en  (pix_en),
    .pix_clk (pix_clk)
  );

  always #5 clk = ~clk;

  function automatic string tname(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int ratio_of(int i);
    if (p_byp[i]) return 1;
    return p_hi[i] * 32 + p_lo[i] + 2;
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check(bit got, bit exp, string req, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic apply(int i);
    bypass = p_byp[i];
    div_lo = 5'(p_lo[i]);
    div_hi = 5'(p_hi[i]);
  endtask

  // Expected waveform of one period: position 0 carries the pulse,
  // low phase ceil(N/2), high phase floor(N/2) (R7)
  task automatic push_period(int i, bit first);
    int n;
    n = ratio_of(i);
    for (int j = first ? 1 : 0; j < n; j++) begin
      item_t it;
      it.en  = (j == 0);
      it.ck  = (j >= (n + 1) / 2);
      it.tag = p_tag[i];
      q.push_back(it);
    end
  endtask

  // Driver
  initial begin
    apply(0);
    push_period(0, 1);
    repeat (4) @(negedge clk);
    check(pix_en, 1'b0, "R1", "pix_en in reset");
    check(pix_clk, 1'b0, "R1", "pix_clk in reset");
    rst_n = 1'b1;
    for (int i = 0; i < NP; i++) begin
      int n;
      int waited;
      n = ratio_of(i);
      waited = 0;
      if (n >= 4) begin
        @(negedge clk);
        waited++;
        // R6: transient wild setting, withdrawn before the boundary
        bypass = 1'b0;
        div_lo = 5'd31;
        div_hi = 5'd31;
      end
      while (waited < n / 2) begin
        @(negedge clk);
        waited++;
      end
      if (i < NP - 1) begin
        apply(i + 1);
        push_period(i + 1, 0);
      end else begin
        apply(i);
      end
      while (waited < n) begin
        @(negedge clk);
        waited++;
      end
    end
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 leftover expected items actual=%0d expected=0", q.size());
    end
    done = 1;
    report();
  end

  // Monitor: pops one expected item per cycle and compares
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        check(pix_en, it.en, (it.tag == 2) ? "R2 R8" : tname(it.tag), "pix_en");
        check(pix_clk, it.ck, (it.tag == 3) ? "R3" : "R7", "pix_clk");
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end
endmodule